// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block guards a memory word with a Hamming code that corrects one flipped bit. On the write side, a data word is spread across a longer code word. Parity bits take every position that is a power of two, and data bits take the remaining positions in ascending order. This path is purely combinational, so its output can go straight to the storage array.

On the read side, the code word fetched from storage is captured on a strobe. The parity is recomputed and compared with the stored parity, and the result is a syndrome. One clock later the block presents the repaired data word along with a set of classification flags. The flags say whether anything was wrong, whether the damage was confined to a parity bit, whether a data bit was flipped back, or whether the syndrome named a position outside the word.

The default build handles 8 data bits in a 12-bit word. Setting `DATA_W` to 16 gives a 21-bit word with 5 parity bits. The memory array itself and double-error detection are not part of this block.

Top module: `hsec_codec`

## Requirements
- R1: With `DATA_W`=8, `wr_code` bit p-1 carries code-word position p. Data bits 0..7 occupy positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R2: With `DATA_W`=8, the parity bits are as follows. Position 1 is the XOR of positions 3, 5, 7, 9 and 11. Position 2 is the XOR of positions 3, 6, 7, 10 and 11. Position 4 is the XOR of positions 5, 6, 7 and 12. Position 8 is the XOR of positions 9 through 12.
- R3: Reading a code word whose syndrome is zero returns its data bits, with all four error flags low.
- R4: A syndrome with exactly one bit set raises `err_detected` and `err_in_check`. The data bits are returned untouched.
- R5: A syndrome with two or more bits set that is no larger than the code width raises `err_detected` and `err_corrected`. The data bit at the position the syndrome names is inverted.
- R6: A syndrome larger than the code width raises `err_detected` and `err_uncorrectable`. The stored data bits are returned unmodified.
- R7: `out_valid` is high in exactly the cycle after a cycle with `rd_valid` high. All error flags are low whenever `out_valid` is low. Back-to-back reads give back-to-back results.
- R8: While reset is asserted, and right after it, `out_valid`, `out_data` and all flags are zero.
- R9: At most one of `err_in_check`, `err_corrected` and `err_uncorrectable` is high. `err_detected` is high exactly when one of them is.
- R10: With `DATA_W`=16, the code word is 21 bits, with parity at positions 1, 2, 4, 8 and 16. Position 1 is the XOR of data bits 0, 1, 3, 4, 6, 8, 10, 11, 13 and 15. A single flipped bit anywhere in the 21 positions is classified and repaired as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | DATA_W | Data word to encode |
| wr_code | output | CODE_W | Encoded word, combinational from `wr_data` |
| rd_valid | input | 1 | Strobe: `rd_code` holds a fetched word |
| rd_code | input | CODE_W | Code word read back from storage |
| out_valid | output | 1 | Result registers hold a decoded word |
| out_data | output | DATA_W | Repaired data word |
| err_detected | output | 1 | Syndrome was nonzero |
| err_in_check | output | 1 | Fault was in a parity bit only |
| err_corrected | output | 1 | A data bit was inverted |
| err_uncorrectable | output | 1 | Syndrome pointed past the last position |

## Verification
The hardest state to reach from the ports is the out-of-range syndrome. A single flipped bit can never produce it. To get there, the stimulus corrupts two positions whose indices XOR to a value above the code width: positions 12 and 1 give 13, positions 12 and 2 give 14, and positions 12 and 3 give 15 in the 8-bit build. In the 16-bit build, positions 16 and 6 give 22. Each position of both builds is also flipped individually, on several data words, in back-to-back and gapped read sequences, so that every parity and data position reaches both repair paths.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    typedef enum logic [1:0] {
        CLS_CLEAN = 2'd0,
        CLS_CHECK = 2'd1,
        CLS_DATA  = 2'd2,
        CLS_BAD   = 2'd3
    } err_class_e;

    // smallest parity count k with 2^k >= data bits + k + 1
    function automatic int parity_bits(input int dw);
        int r;
        r = 0;
        for (int k = 31; k >= 1; k--) begin
            if ((64'd1 << k) >= 64'(dw + k + 1)) r = k;
        end
        return r;
    endfunction

    // 1-based code position of data bit i (0-based)
    function automatic int data_pos(input int i, input int cw);
        int n;
        int r;
        n = 0;
        r = 0;
        for (int p = 1; p <= 64; p++) begin
            if (p <= cw && (p & (p - 1)) != 0) begin
                if (n == i) r = p;
                n++;
            end
        end
        return r;
    endfunction

    // data index held at a non-power-of-two position p
    function automatic int data_idx(input int p);
        return p - $clog2(p + 1) - 1;
    endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_W = 12
) (
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);
    import hsec_pkg::*;

    logic [CHK_W-1:0] par_d;

    always_comb begin
        par_d = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (((data_pos(i, CODE_W) >> k) & 1) == 1) par_d[k] = par_d[k] ^ data[i];
            end
        end
    end

    for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
        if ((p & (p - 1)) == 0) begin : g_par
            assign code[p-1] = par_d[$clog2(p)];
        end else begin : g_dat
            assign code[p-1] = data[data_idx(p)];
        end
    end

endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
    parameter int CHK_W  = 4,
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] code,
    output logic [CHK_W-1:0]  syn
);
    // stored parity XOR recomputed parity == XOR over every covered position
    always_comb begin
        syn = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int p = 1; p <= CODE_W; p++) begin
                if (((p >> k) & 1) == 1) syn[k] = syn[k] ^ code[p-1];
            end
        end
    end

endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector
    import hsec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CHK_W-1:0]  syn,
    output logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] fixed,
    output err_class_e        cls
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_ext
        localparam int POS = data_pos(i, CODE_W);
        assign raw[i]   = code[POS-1];
        assign fixed[i] = raw[i] ^ ((cls == CLS_DATA) && (int'(syn) == POS));
    end

    always_comb begin
        if (syn == '0)                  cls = CLS_CLEAN;
        else if ($onehot(syn))          cls = CLS_CHECK;
        else if (int'(syn) > CODE_W)    cls = CLS_BAD;
        else                            cls = CLS_DATA;
    end

endmodule

// File: rtl/hsec_codec.sv
module hsec_codec
    import hsec_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W  = parity_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] wr_code,
    input  logic              rd_valid,
    input  logic [CODE_W-1:0] rd_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              err_detected,
    output logic              err_in_check,
    output logic              err_corrected,
    output logic              err_uncorrectable
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              det;
        logic              chk;
        logic              cor;
        logic              bad;
    } rd_state_t;

    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] fixed;
    err_class_e        cls;
    rd_state_t         st_d, st_q;

    hsec_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_enc (
        .data (wr_data),
        .code (wr_code)
    );

    hsec_syndrome #(.CHK_W(CHK_W), .CODE_W(CODE_W)) u_syn (
        .code (rd_code),
        .syn  (syn)
    );

    hsec_corrector #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_cor (
        .code  (rd_code),
        .syn   (syn),
        .raw   (raw),
        .fixed (fixed),
        .cls   (cls)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_valid;
        st_d.det = 1'b0;
        st_d.chk = 1'b0;
        st_d.cor = 1'b0;
        st_d.bad = 1'b0;
        if (rd_valid) begin
            st_d.data = fixed;
            st_d.det  = (cls != CLS_CLEAN);
            st_d.chk  = (cls == CLS_CHECK);
            st_d.cor  = (cls == CLS_DATA);
            st_d.bad  = (cls == CLS_BAD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid         = st_q.vld;
    assign out_data          = st_q.data;
    assign err_detected      = st_q.det;
    assign err_in_check      = st_q.chk;
    assign err_corrected     = st_q.cor;
    assign err_uncorrectable = st_q.bad;

    // R7: result appears exactly one cycle after the strobe
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);
    p_valid_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid && !err_detected);

    // R9: classes are exclusive
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_in_check, err_corrected, err_uncorrectable}));

    // R3: zero syndrome gives a clean result
    p_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && syn == '0 |=> !err_detected && out_data == $past(raw));

    // R4: single-bit syndrome leaves data alone
    p_check_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && $onehot(syn) |=> err_in_check && out_data == $past(raw));

    // R5: repair changes exactly one data bit
    p_one_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && cls == CLS_DATA |=> err_corrected && $countones(out_data ^ $past(raw)) == 1);

endmodule

// File: tb/hsec_codec_tb.sv
`timescale 1ns/1ps
module hsec_codec_tb;

    typedef struct {
        logic [15:0] data;
        logic        det;
        logic        chk;
        logic        cor;
        logic        bad;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  w8_data = '0;
    logic [11:0] w8_code;
    logic        r8_v = 1'b0;
    logic [11:0] r8_code = '0;
    logic        o8_v, o8_det, o8_chk, o8_cor, o8_bad;
    logic [7:0]  o8_data;

    logic [15:0] w16_data = '0;
    logic [20:0] w16_code;
    logic        r16_v = 1'b0;
    logic [20:0] r16_code = '0;
    logic        o16_v, o16_det, o16_chk, o16_cor, o16_bad;
    logic [15:0] o16_data;

    hsec_codec #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_data(w8_data), .wr_code(w8_code),
        .rd_valid(r8_v), .rd_code(r8_code), .out_valid(o8_v), .out_data(o8_data),
        .err_detected(o8_det), .err_in_check(o8_chk), .err_corrected(o8_cor),
        .err_uncorrectable(o8_bad));

    hsec_codec #(.DATA_W(16)) u_dut16 (
        .clk(clk), .rst_n(rst_n), .wr_data(w16_data), .wr_code(w16_code),
        .rd_valid(r16_v), .rd_code(r16_code), .out_valid(o16_v), .out_data(o16_data),
        .err_detected(o16_det), .err_in_check(o16_chk), .err_corrected(o16_cor),
        .err_uncorrectable(o16_bad));

    exp_t q8[$];
    exp_t q16[$];

    task automatic check(input string req, input bit ok, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // reference model built from the requirement text
    function automatic logic [20:0] ref_enc(input int dw, input logic [15:0] d);
        logic [20:0] c;
        int cw;
        int n;
        cw = (dw == 8) ? 12 : 21;
        c = '0;
        n = 0;
        for (int p = 1; p <= cw; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p-1] = d[n];
                n++;
            end
        end
        for (int k = 0; k < 5; k++) begin
            if ((1 << k) <= cw) begin
                logic par;
                par = 1'b0;
                for (int p = 1; p <= cw; p++)
                    if ((p & (p - 1)) != 0 && ((p >> k) & 1) == 1) par ^= c[p-1];
                c[(1 << k) - 1] = par;
            end
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_ext(input int dw, input logic [20:0] c);
        logic [15:0] d;
        int cw;
        int n;
        cw = (dw == 8) ? 12 : 21;
        d = '0;
        n = 0;
        for (int p = 1; p <= cw; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[n] = c[p-1];
                n++;
            end
        end
        return d;
    endfunction

    function automatic exp_t mk(input logic [15:0] d, input int kind);
        exp_t e;
        e.data = d;
        e.det  = (kind != 0);
        e.chk  = (kind == 1);
        e.cor  = (kind == 2);
        e.bad  = (kind == 3);
        return e;
    endfunction

    task automatic rd8(input logic [11:0] c, input exp_t e);
        @(negedge clk);
        r8_v = 1'b1;
        r8_code = c;
        q8.push_back(e);
    endtask

    task automatic rd16(input logic [20:0] c, input exp_t e);
        @(negedge clk);
        r16_v = 1'b1;
        r16_code = c;
        q16.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        r8_v = 1'b0;
        r16_v = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitors
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (o8_v) begin
                if (q8.size() == 0) check("R7 unexpected out_valid (8b)", 1'b0, 1, 0);
                else begin
                    exp_t e;
                    e = q8.pop_front();
                    check("R3/R4/R5/R6 data (8b)", o8_data == e.data[7:0], o8_data, e.data[7:0]);
                    check("R9 flags (8b)", {o8_det, o8_chk, o8_cor, o8_bad} == {e.det, e.chk, e.cor, e.bad},
                          {o8_det, o8_chk, o8_cor, o8_bad}, {e.det, e.chk, e.cor, e.bad});
                end
            end else begin
                check("R7 flags low when idle (8b)", {o8_det, o8_chk, o8_cor, o8_bad} == 4'b0,
                      {o8_det, o8_chk, o8_cor, o8_bad}, 0);
            end
            if (o16_v) begin
                if (q16.size() == 0) check("R7 unexpected out_valid (16b)", 1'b0, 1, 0);
                else begin
                    exp_t e;
                    e = q16.pop_front();
                    check("R10 data (16b)", o16_data == e.data, o16_data, e.data);
                    check("R10 flags (16b)", {o16_det, o16_chk, o16_cor, o16_bad} == {e.det, e.chk, e.cor, e.bad},
                          {o16_det, o16_chk, o16_cor, o16_bad}, {e.det, e.chk, e.cor, e.bad});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1'b0, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  vec8 [4]  = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
        logic [15:0] vec16 [3] = '{16'h0000, 16'h503C, 16'hFFFF};

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 reset outputs", {o8_v, o8_data, o8_det, o8_chk, o8_cor, o8_bad} == '0,
              {o8_v, o8_data, o8_det, o8_chk, o8_cor, o8_bad}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", {o8_v, o8_data, o16_v, o16_data} == '0, {o8_v, o8_data, o16_v, o16_data}, 0);

        // R1, R2: exhaustive encode with explicit position equations
        for (int d = 0; d < 256; d++) begin
            logic [11:0] c;
            logic [7:0]  pl;
            logic [3:0]  pb;
            w8_data = 8'(d);
            #1;
            c = w8_code;
            pl = {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
            check("R1 data placement", pl == 8'(d), pl, d);
            pb = {c[11] ^ c[10] ^ c[9] ^ c[8],
                  c[11] ^ c[6] ^ c[5] ^ c[4],
                  c[10] ^ c[9] ^ c[6] ^ c[5] ^ c[2],
                  c[10] ^ c[8] ^ c[6] ^ c[4] ^ c[2]};
            check("R2 parity equations", pb == {c[7], c[3], c[1], c[0]}, {c[7], c[3], c[1], c[0]}, pb);
        end

        // R10: 16-bit encode
        foreach (vec16[j]) begin
            logic p1;
            w16_data = vec16[j];
            #1;
            p1 = ^(vec16[j] & 16'b1010_1101_0101_1011);
            check("R10 encode", w16_code == ref_enc(16, vec16[j]), w16_code, ref_enc(16, vec16[j]));
            check("R10 position-1 parity", w16_code[0] == p1, w16_code[0], p1);
        end

        // R3: clean reads, back to back (R7)
        foreach (vec8[j]) rd8(ref_enc(8, 16'(vec8[j])), mk(16'(vec8[j]), 0));
        idle(2);

        // R4/R5: every single-position flip, with gaps between groups
        foreach (vec8[j]) begin
            for (int p = 1; p <= 12; p++) begin
                logic [11:0] c;
                c = 12'(ref_enc(8, 16'(vec8[j])));
                c[p-1] = ~c[p-1];
                rd8(c, mk(16'(vec8[j]), ((p & (p - 1)) == 0) ? 1 : 2));
            end
            idle(1);
        end

        // R6: double flips whose syndrome exceeds 12 (13, 14, 15)
        foreach (vec8[j]) begin
            for (int s = 1; s <= 3; s++) begin
                logic [11:0] c;
                c = 12'(ref_enc(8, 16'(vec8[j])));
                c[11] = ~c[11];
                c[s-1] = ~c[s-1];
                rd8(c, mk(ref_ext(8, 21'(c)), 3));
            end
        end
        idle(2);

        // R10: 16-bit single flips and an out-of-range double flip (16^6 = 22)
        foreach (vec16[j]) begin
            logic [20:0] c;
            rd16(ref_enc(16, vec16[j]), mk(vec16[j], 0));
            for (int p = 1; p <= 21; p++) begin
                c = ref_enc(16, vec16[j]);
                c[p-1] = ~c[p-1];
                rd16(c, mk(vec16[j], ((p & (p - 1)) == 0) ? 1 : 2));
            end
            c = ref_enc(16, vec16[j]);
            c[15] = ~c[15];
            c[5] = ~c[5];
            rd16(c, mk(ref_ext(16, c), 3));
        end
        idle(4);

        check("R7 all reads answered (8b)", q8.size() == 0, q8.size(), 0);
        check("R7 all reads answered (16b)", q16.size() == 0, q16.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule